// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It is clocked by the test clock and steered by the mode-select input. It holds the sixteen-state test-port state machine, a four-bit instruction register, a one-bit bypass stage, a 32-bit identification register and a boundary scan chain whose length is a parameter. The active instruction is decoded so that exactly one of these registers sits between the serial data input and the serial data output. The same decode produces the mode flags that the pad ring uses to drive pins from the boundary update latch, to float them, or to hold them.

A power-on reset, or five rising test-clock edges with mode-select held high, returns the controller to its idle reset state. In that state the active instruction is the identification instruction and every test-mode flag is low, so the system pins run as normal. Serial output changes on the falling test-clock edge and is enabled only while an instruction or data register is shifting.

Top module: `jtag_tap`

## Requirements
- R1: A low level on `por_n` at once, without a clock edge, forces the state machine to Test-Logic-Reset, the active instruction to IDCODE (0000), `tdo` and `tdo_oe` to 0, all mode flags to 0 and `bsr_upd_o` to 0.
- R2: From any state, five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset, and the following data scan returns the identification value.
- R3: In Test-Logic-Reset the active instruction becomes IDCODE (0000). That instruction selects a 32-bit register that is loaded with parameter `IDCODE_VAL` (bit 0 is 1) in Capture-DR and shifts out with bit 0 first.
- R4: Capture-IR loads the pattern 0001 into the instruction shift stage, so the first four bits shifted out in Shift-IR are 1, 0, 0, 0.
- R5: The instruction shifts in with bit 0 first, and the active instruction changes only on the falling `tck` edge in Update-IR. The shift stage keeps its contents through Pause-IR.
- R6: SAMPLE/PRELOAD (0001), SAMPLE (0010) and EXTEST (0011) select the boundary chain of `BSR_LEN` bits. It captures `sys_in` in Capture-DR, shifts toward bit 0 with `tdi` entering at the top bit, and copies into `bsr_upd_o` on the falling edge in Update-DR.
- R7: BYPASS (1111), HIGHZ (1001), CLAMP (1100) and every opcode not listed in R3 or R6 select the one-bit bypass stage. It captures 0 in Capture-DR and delays `tdi` to `tdo` by exactly one `tck`.
- R8: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 exactly while the state is Shift-IR or Shift-DR, and `tdo` is 0 when `tdo_oe` is 0.
- R9: `extest_o`, `highz_o` and `clamp_o` are high exactly while EXTEST, HIGHZ or CLAMP is the active instruction. They change only when Update-IR or reset changes that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| sys_in | input | BSR_LEN | Pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| extest_o | output | 1 | Pins driven from the boundary update latch |
| highz_o | output | 1 | Pins to be floated |
| clamp_o | output | 1 | Pins held at the update latch value |
| bsr_upd_o | output | BSR_LEN | Boundary update latch |

## Verification
A wrong state-machine state shows up within one falling edge as a wrong `tdo_oe`, or as a scan whose output pattern has the wrong length or content. A wrong active instruction shows up on the mode flags at the falling edge of Update-IR. It also shows up in the next data scan, because the selected path's capture value and length appear on `tdo` bit by bit. The bench tracks state, instruction, every shift stage and the update latch. It compares all outputs on every falling edge, so a fault is reported in the cycle where it first reaches a pin.

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
package jtag_tap_pkg;

    typedef enum logic [3:0] {
        ST_EX2_DR = 4'h0,
        ST_EX1_DR = 4'h1,
        ST_SH_DR  = 4'h2,
        ST_PAU_DR = 4'h3,
        ST_SEL_IR = 4'h4,
        ST_UPD_DR = 4'h5,
        ST_CAP_DR = 4'h6,
        ST_SEL_DR = 4'h7,
        ST_EX2_IR = 4'h8,
        ST_EX1_IR = 4'h9,
        ST_SH_IR  = 4'hA,
        ST_PAU_IR = 4'hB,
        ST_RTI    = 4'hC,
        ST_UPD_IR = 4'hD,
        ST_CAP_IR = 4'hE,
        ST_TLR    = 4'hF
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS = 2'd0,
        PATH_IDCODE = 2'd1,
        PATH_BSR    = 2'd2
    } dr_path_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e state;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.state = tap_next(fsm_q.state, tms);
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) fsm_q <= '{state: ST_TLR};
        else        fsm_q <= fsm_d;
    end

    assign state_o = fsm_q.state;

    // Checker support: run length of tms-high edges, saturating
    logic [2:0] hi_run_q;
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)             hi_run_q <= '0;
        else if (!tms)          hi_run_q <= '0;
        else if (hi_run_q != 3'd7) hi_run_q <= hi_run_q + 3'd1;
    end

    AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!por_n)
        (hi_run_q >= 3'd5) |-> (fsm_q.state == ST_TLR)); // R2

endmodule

// File: rtl/jtag_tap_ir.sv
`timescale 1ns/1ps
module jtag_tap_ir
    import jtag_tap_pkg::*;
#(
    parameter int              IR_W        = 4,
    parameter logic [IR_W-1:0] CAPTURE_PAT = 4'b0001,
    parameter logic [IR_W-1:0] RESET_OP    = 4'b0000
) (
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      state_i,
    input  logic            tdi,
    output logic            sh_lsb_o,
    output logic [IR_W-1:0] ir_o
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
    } ir_pos_t;

    typedef struct packed {
        logic [IR_W-1:0] act;
    } ir_neg_t;

    ir_pos_t pos_d, pos_q;
    ir_neg_t neg_d, neg_q;

    always_comb begin
        pos_d = pos_q;
        if (state_i == ST_CAP_IR)     pos_d.sh = CAPTURE_PAT;
        else if (state_i == ST_SH_IR) pos_d.sh = {tdi, pos_q.sh[IR_W-1:1]};
    end

    always_comb begin
        neg_d = neg_q;
        if (state_i == ST_TLR)         neg_d.act = RESET_OP;
        else if (state_i == ST_UPD_IR) neg_d.act = pos_q.sh;
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) neg_q <= '{act: RESET_OP};
        else        neg_q <= neg_d;
    end

    assign sh_lsb_o = pos_q.sh[0];
    assign ir_o     = neg_q.act;

    AST_IR_RESET_VALUE: assert property (@(posedge tck) disable iff (!por_n)
        (state_i == ST_TLR) |-> (neg_q.act == RESET_OP)); // R3

    AST_IR_UPDATE_ONLY: assert property (@(posedge tck) disable iff (!por_n)
        !(state_i == ST_UPD_IR || state_i == ST_TLR) |-> $stable(neg_q.act)); // R5

endmodule

// File: rtl/jtag_tap_dr.sv
`timescale 1ns/1ps
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int              BSR_LEN    = 8,
    parameter int              ID_W       = 32,
    parameter logic [ID_W-1:0] IDCODE_VAL = 32'h1A5C_301D
) (
    input  logic               tck,
    input  logic               por_n,
    input  tap_state_e         state_i,
    input  dr_path_e           path_i,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] sys_in,
    output logic               dr_lsb_o,
    output logic [BSR_LEN-1:0] bsr_upd_o
);

    typedef struct packed {
        logic               byp;
        logic [ID_W-1:0]    id;
        logic [BSR_LEN-1:0] bsr;
    } dr_pos_t;

    typedef struct packed {
        logic [BSR_LEN-1:0] upd;
    } dr_neg_t;

    dr_pos_t pos_d, pos_q;
    dr_neg_t neg_d, neg_q;
    logic [BSR_LEN-1:0] bsr_shifted;

    generate
        if (BSR_LEN == 1) begin : g_bsr_single
            assign bsr_shifted = tdi;
        end else begin : g_bsr_chain
            assign bsr_shifted = {tdi, pos_q.bsr[BSR_LEN-1:1]};
        end
    endgenerate

    always_comb begin
        pos_d = pos_q;
        if (state_i == ST_CAP_DR) begin
            case (path_i)
                PATH_IDCODE: pos_d.id  = IDCODE_VAL;
                PATH_BSR:    pos_d.bsr = sys_in;
                default:     pos_d.byp = 1'b0;
            endcase
        end else if (state_i == ST_SH_DR) begin
            case (path_i)
                PATH_IDCODE: pos_d.id  = {tdi, pos_q.id[ID_W-1:1]};
                PATH_BSR:    pos_d.bsr = bsr_shifted;
                default:     pos_d.byp = tdi;
            endcase
        end
    end

    always_comb begin
        neg_d = neg_q;
        if (state_i == ST_UPD_DR && path_i == PATH_BSR) neg_d.upd = pos_q.bsr;
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) neg_q <= '0;
        else        neg_q <= neg_d;
    end

    always_comb begin
        case (path_i)
            PATH_IDCODE: dr_lsb_o = pos_q.id[0];
            PATH_BSR:    dr_lsb_o = pos_q.bsr[0];
            default:     dr_lsb_o = pos_q.byp;
        endcase
    end

    assign bsr_upd_o = neg_q.upd;

    AST_BYPASS_ONE_CYCLE: assert property (@(posedge tck) disable iff (!por_n)
        ($past(state_i) == ST_SH_DR && $past(path_i) == PATH_BYPASS && path_i == PATH_BYPASS)
        |-> (dr_lsb_o == $past(tdi))); // R7

    AST_UPD_HOLDS: assert property (@(posedge tck) disable iff (!por_n)
        (state_i != ST_UPD_DR) |-> $stable(neg_q.upd)); // R6

endmodule

// File: rtl/jtag_tap.sv
`timescale 1ns/1ps
module jtag_tap
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN           = 8,
    parameter int          IR_W              = 4,
    parameter logic [31:0] IDCODE_VAL        = 32'h1A5C_301D,
    parameter logic [IR_W-1:0] OP_IDCODE     = 4'b0000,
    parameter logic [IR_W-1:0] OP_SAMPLE_PRE = 4'b0001,
    parameter logic [IR_W-1:0] OP_SAMPLE     = 4'b0010,
    parameter logic [IR_W-1:0] OP_EXTEST     = 4'b0011,
    parameter logic [IR_W-1:0] OP_HIGHZ      = 4'b1001,
    parameter logic [IR_W-1:0] OP_CLAMP      = 4'b1100,
    parameter logic [IR_W-1:0] OP_BYPASS     = 4'b1111,
    parameter logic [IR_W-1:0] IR_CAPTURE    = 4'b0001
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] sys_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               extest_o,
    output logic               highz_o,
    output logic               clamp_o,
    output logic [BSR_LEN-1:0] bsr_upd_o
);

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_regs_t;

    tap_state_e      state;
    logic [IR_W-1:0] ir_act;
    logic            ir_lsb;
    logic            dr_lsb;
    dr_path_e        path;
    out_regs_t       out_d, out_q;

    jtag_tap_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .tms     (tms),
        .state_o (state)
    );

    jtag_tap_ir #(
        .IR_W        (IR_W),
        .CAPTURE_PAT (IR_CAPTURE),
        .RESET_OP    (OP_IDCODE)
    ) u_ir (
        .tck      (tck),
        .por_n    (por_n),
        .state_i  (state),
        .tdi      (tdi),
        .sh_lsb_o (ir_lsb),
        .ir_o     (ir_act)
    );

    // Instruction decode: one data path per instruction
    always_comb begin
        if (ir_act == OP_IDCODE)
            path = PATH_IDCODE;
        else if (ir_act == OP_SAMPLE_PRE || ir_act == OP_SAMPLE || ir_act == OP_EXTEST)
            path = PATH_BSR;
        else if (ir_act == OP_BYPASS || ir_act == OP_HIGHZ || ir_act == OP_CLAMP)
            path = PATH_BYPASS;
        else
            path = PATH_BYPASS;
    end

    jtag_tap_dr #(
        .BSR_LEN    (BSR_LEN),
        .ID_W       (32),
        .IDCODE_VAL (IDCODE_VAL)
    ) u_dr (
        .tck       (tck),
        .por_n     (por_n),
        .state_i   (state),
        .path_i    (path),
        .tdi       (tdi),
        .sys_in    (sys_in),
        .dr_lsb_o  (dr_lsb),
        .bsr_upd_o (bsr_upd_o)
    );

    always_comb begin
        out_d     = out_q;
        out_d.oe  = (state == ST_SH_IR) || (state == ST_SH_DR);
        if (state == ST_SH_IR)      out_d.tdo = ir_lsb;
        else if (state == ST_SH_DR) out_d.tdo = dr_lsb;
        else                        out_d.tdo = 1'b0;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tdo      = out_q.tdo;
    assign tdo_oe   = out_q.oe;
    assign extest_o = (ir_act == OP_EXTEST);
    assign highz_o  = (ir_act == OP_HIGHZ);
    assign clamp_o  = (ir_act == OP_CLAMP);

    AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe == (state == ST_SH_IR || state == ST_SH_DR)); // R8

    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!por_n)
        !tdo_oe |-> !tdo); // R8

    AST_MODES_OFF_IN_RESET: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_TLR) |-> !(extest_o || highz_o || clamp_o)); // R9

endmodule

// File: tb/jtag_tap_tb.sv
`timescale 1ns/1ps
module jtag_tap_tb;

    localparam int BSR = 8;
    localparam logic [31:0] IDV = 32'h1A5C_301D;

    localparam int S_TLR=0, S_RTI=1, S_SDR=2, S_CDR=3, S_SHDR=4, S_E1DR=5, S_PDR=6,
                   S_E2DR=7, S_UDR=8, S_SIR=9, S_CIR=10, S_SHIR=11, S_E1IR=12,
                   S_PIR=13, S_E2IR=14, S_UIR=15;

    logic tck = 1'b0;
    logic por_n, tms, tdi;
    logic [BSR-1:0] sys_in;
    logic tdo, tdo_oe, extest_o, highz_o, clamp_o;
    logic [BSR-1:0] bsr_upd_o;

    jtag_tap u_dut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .sys_in(sys_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .extest_o(extest_o), .highz_o(highz_o),
        .clamp_o(clamp_o), .bsr_upd_o(bsr_upd_o)
    );

    always #2.5 tck = ~tck;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string req = "R1";

    // Behavioural reference
    int m_st;
    logic [3:0] m_ir, m_irsh;
    logic m_byp, m_tdo, m_oe;
    logic [31:0] m_id;
    logic [BSR-1:0] m_bsr, m_upd;

    function automatic int nxt(int s, logic t);
        case (s)
            S_TLR:  return t ? S_TLR : S_RTI;
            S_RTI:  return t ? S_SDR : S_RTI;
            S_SDR:  return t ? S_SIR : S_CDR;
            S_CDR:  return t ? S_E1DR : S_SHDR;
            S_SHDR: return t ? S_E1DR : S_SHDR;
            S_E1DR: return t ? S_UDR : S_PDR;
            S_PDR:  return t ? S_E2DR : S_PDR;
            S_E2DR: return t ? S_UDR : S_SHDR;
            S_UDR:  return t ? S_SDR : S_RTI;
            S_SIR:  return t ? S_TLR : S_CIR;
            S_CIR:  return t ? S_E1IR : S_SHIR;
            S_SHIR: return t ? S_E1IR : S_SHIR;
            S_E1IR: return t ? S_UIR : S_PIR;
            S_PIR:  return t ? S_E2IR : S_PIR;
            S_E2IR: return t ? S_UIR : S_SHIR;
            default: return t ? S_SDR : S_RTI;
        endcase
    endfunction

    // 1 = id, 2 = boundary chain, 0 = bypass
    function automatic int sel(logic [3:0] op);
        if (op == 4'b0000) return 1;
        if (op == 4'b0001 || op == 4'b0010 || op == 4'b0011) return 2;
        return 0;
    endfunction

    task automatic m_reset();
        m_st = S_TLR; m_ir = 4'b0000; m_irsh = '0; m_byp = 0; m_id = '0;
        m_bsr = '0; m_upd = '0; m_tdo = 0; m_oe = 0;
    endtask

    task automatic m_rise(logic t, logic d);
        int p = sel(m_ir);
        if (m_st == S_CIR) m_irsh = 4'b0001;
        if (m_st == S_SHIR) m_irsh = {d, m_irsh[3:1]};
        if (m_st == S_CDR) begin
            if (p == 1) m_id = IDV; else if (p == 2) m_bsr = sys_in; else m_byp = 0;
        end
        if (m_st == S_SHDR) begin
            if (p == 1) m_id = {d, m_id[31:1]};
            else if (p == 2) m_bsr = {d, m_bsr[BSR-1:1]};
            else m_byp = d;
        end
        m_st = nxt(m_st, t);
    endtask

    task automatic m_fall();
        int p = sel(m_ir);
        m_oe = (m_st == S_SHIR || m_st == S_SHDR);
        if (m_st == S_SHIR) m_tdo = m_irsh[0];
        else if (m_st == S_SHDR) m_tdo = (p == 1) ? m_id[0] : (p == 2) ? m_bsr[0] : m_byp;
        else m_tdo = 0;
        if (m_st == S_TLR) m_ir = 4'b0000;
        else if (m_st == S_UIR) m_ir = m_irsh;
        if (m_st == S_UDR && p == 2) m_upd = m_bsr;
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("tdo", tdo, m_tdo);
        chk("tdo_oe", tdo_oe, m_oe);
        chk("extest_o", extest_o, m_ir == 4'b0011);
        chk("highz_o", highz_o, m_ir == 4'b1001);
        chk("clamp_o", clamp_o, m_ir == 4'b1100);
        chk("bsr_upd_o", bsr_upd_o, m_upd);
    endtask

    // Called one time unit after a falling edge
    task automatic step(logic t, logic d);
        tms = t; tdi = d;
        @(posedge tck); m_rise(t, d);
        @(negedge tck); m_fall();
        #1 compare_all();
    endtask

    task automatic shift_ir(logic [3:0] op);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) step(i == 3, op[i]);
        step(1, 0); step(0, 0);
    endtask

    task automatic shift_dr(int n, logic [63:0] data);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) step(i == n - 1, data[i]);
        step(1, 0); step(0, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        por_n = 0; tms = 1; tdi = 0; sys_in = '0;
        m_reset();
        repeat (3) @(negedge tck);
        #1 req = "R1"; compare_all();
        por_n = 1;
        step(0, 0);

        req = "R3"; shift_dr(32, 64'h0000_0000_F0F0_1234);
        req = "R4"; shift_ir(4'b1111);
        req = "R7"; shift_dr(12, 64'hB5A);

        req = "R6"; sys_in = 8'hA5;
        shift_ir(4'b0001); shift_dr(8, 64'h3C);
        sys_in = 8'h5A;
        shift_ir(4'b0010); shift_dr(8, 64'h96);
        shift_ir(4'b0011); sys_in = 8'h0F; shift_dr(8, 64'hC3);

        req = "R9";
        shift_ir(4'b1001); shift_dr(5, 64'h15);
        shift_ir(4'b1100); shift_dr(5, 64'h0A);
        shift_ir(4'b0011);

        req = "R7";
        foreach (lfsr[k]) begin
            logic [3:0] op = 4'(k);
            if (sel(op) == 0 && op != 4'b1111) begin
                shift_ir(op); shift_dr(6, 64'h2D);
            end
        end

        req = "R5";   // scan through Pause-IR, instruction EXTEST
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        step(0, 1); step(1, 1);
        step(0, 0); step(0, 0); step(1, 0); step(0, 0);
        step(0, 0); step(1, 0);
        step(1, 0); step(0, 0);
        shift_dr(8, 64'h81);

        req = "R8";
        step(1, 0); step(0, 0); step(0, 0); step(0, 1); step(1, 1);
        step(0, 0); step(0, 0); step(1, 0); step(0, 1); step(1, 0);
        step(1, 0); step(0, 0);

        req = "R2";
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 300; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                sys_in = lfsr[11:4];
                step(lfsr[0] & lfsr[3], lfsr[7]);
            end
            for (int i = 0; i < 5; i++) step(1, lfsr[i]);
            step(0, 0);
            shift_dr(32, 64'h55AA_33CC);
        end

        req = "R1";   // asynchronous reset in the middle of an EXTEST data shift
        shift_ir(4'b0011);
        step(1, 0); step(0, 0); step(0, 0); step(0, 1); step(0, 1);
        #0.5 por_n = 0;
        #0.5 m_reset(); compare_all();
        @(negedge tck); #1 por_n = 1; compare_all();
        step(0, 0);
        shift_dr(32, 64'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule